// File: doc/BRIEF.md
# Shift-Scaled Multi-Channel PWM Timer

This block generates pulse-width-modulated outputs on several channels from one shared free-running counter. A power-of-two scale setting picks which window of counter bits reaches a set of fixed-width comparators. The period is therefore 2^(CMP_W+scale) clock cycles, where CMP_W is the comparator width (16 by default). Each channel has its own compare value. That value sets how long the output sits at its active level. The outputs are active low.

Software reaches the block through a simple 32-bit register bus. The registers are a configuration word, the raw counter, the scaled counter and one compare register per channel. The counter runs in one of two modes. In the continuous mode it runs until it is switched off. In the single-period mode it runs one period and then stops by itself. Each channel has a compare-match flag, read back in the upper bits of the configuration word. The period and the compare values are separate registers with no double buffering. A change to either one takes effect on the next cycle.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped at zero and every output is high.
- R2: The configuration word is at offset 0x00. The raw counter is at 0x08 and the scaled counter is at 0x10. Compare register n is at 0x20+4n and keeps the low CMP_W bits of a write. Any other offset reads zero. Configuration bits 3:0, 8, 9, 10, 12, 13, 16 and 24 are stored as written. All other configuration bits read zero apart from the match flags.
- R3: When configuration bit 12 (continuous) or bit 13 (single period) is set, the raw counter advances by one each cycle. It returns to zero after the count 2^(CMP_W+scale)-1, where scale is configuration bits 3:0. When both bits are clear, the counter holds its value.
- R4: The scaled counter reads counter bits [scale+CMP_W-1 : scale], zero-extended.
- R5: While the counter runs, output n is low exactly when the scaled count is less than compare n. Otherwise the output is high.
- R6: A compare value of 0 never drives its output low. The largest compare value drives the output low for all scaled steps of a period except the last one, so the output is never low for a whole period.
- R7: While the counter is stopped, every output stays high whatever the compare values are.
- R8: In single-period mode the counter runs one full period. When it returns to zero, bit 13 clears itself and the counter stays at zero.
- R9: The match flag of channel n is at configuration bit 28+n. It sets on a running cycle whose scaled count is greater than or equal to compare n. It clears when the counter returns to zero or the raw counter is written. Writes to the flag bits are ignored.
- R10: A write to the raw counter loads it with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_n | output | NCH | Active-low PWM outputs |

## Verification
The bench builds the block with a 4-bit comparator instead of 16 bits, so the shortest period is 16 cycles rather than 65536. The raw counter then becomes 19 bits wide. These values put full periods, counter wraps, single-period completion and the all-but-one-step duty within a few hundred cycles. The scale mapping is still exercised at four scale values, and every channel is reachable.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int SCALE_W  = 4;
    localparam int FLAG_LSB = 28;

    localparam logic [7:0] OFS_CFG  = 8'h00;
    localparam logic [7:0] OFS_RAW  = 8'h08;
    localparam logic [7:0] OFS_SCL  = 8'h10;
    localparam logic [7:0] OFS_CMP0 = 8'h20;

    typedef struct packed {
        logic               gang;
        logic               center;
        logic               once;
        logic               always_on;
        logic               deglitch;
        logic               zero_rst;
        logic               sticky;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

    function automatic logic [31:0] cfg_to_word(cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[3:0]   = c.scale;
        w[8]     = c.sticky;
        w[9]     = c.zero_rst;
        w[10]    = c.deglitch;
        w[12]    = c.always_on;
        w[13]    = c.once;
        w[16]    = c.center;
        w[24]    = c.gang;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(logic [31:0] w);
        cfg_t c;
        c.scale     = w[3:0];
        c.sticky    = w[8];
        c.zero_rst  = w[9];
        c.deglitch  = w[10];
        c.always_on = w[12];
        c.once      = w[13];
        c.center    = w[16];
        c.gang      = w[24];
        return c;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int CNT_W = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   cnt,
    output logic [CMP_W-1:0]   scaled,
    output logic               wrap
);

    localparam logic [CNT_W:0] ONE_W = 1;

    logic [CNT_W:0]   last;
    logic [CNT_W-1:0] shifted;

    always_comb begin
        last    = (ONE_W << (CMP_W + 32'(scale))) - ONE_W;
        wrap    = run && ({1'b0, cnt} >= last);
        shifted = cnt >> scale;
        scaled  = shifted[CMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (wrap)
            cnt <= '0;
        else if (run)
            cnt <= cnt + CNT_W'(1);
    end

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt));
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (wrap && !load) |=> (cnt == '0));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    output logic             out_n,
    output logic             flag
);

    logic below;

    always_comb begin
        below = scaled < cmp;
        out_n = !(run && below);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            flag <= 1'b0;
        else if (run && !below)
            flag <= 1'b1;
    end

    a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
        !run |-> out_n);
    a_r6_zero_inactive: assert property (@(posedge clk) disable iff (rst)
        (cmp == '0) |-> out_n);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);
    a_r9_hold_set: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CMP_W = 16,
    parameter int CNT_W = 31
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [CMP_W-1:0]          scaled,
    input  logic [NCH-1:0]            flags,
    input  logic                      once_done,
    output cfg_t                      cfg,
    output logic [NCH-1:0][CMP_W-1:0] cmp,
    output logic                      cnt_load,
    output logic [CNT_W-1:0]          cnt_val
);

    logic wr, cfg_wr;

    assign wr       = bus_sel && bus_we;
    assign cfg_wr   = wr && (bus_addr == OFS_CFG);
    assign cnt_load = wr && (bus_addr == OFS_RAW);
    assign cnt_val  = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (cfg_wr)
            cfg <= word_to_cfg(bus_wdata);
        else if (once_done)
            cfg.once <= 1'b0;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        localparam logic [7:0] OFS = OFS_CMP0 + 8'(4 * i);
        always_ff @(posedge clk) begin
            if (rst)
                cmp[i] <= '0;
            else if (wr && bus_addr == OFS)
                cmp[i] <= bus_wdata[CMP_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CFG) begin
            bus_rdata = cfg_to_word(cfg);
            bus_rdata[FLAG_LSB +: NCH] = flags;
        end else if (bus_addr == OFS_RAW) begin
            bus_rdata = 32'(cnt);
        end else if (bus_addr == OFS_SCL) begin
            bus_rdata = 32'(scaled);
        end
        for (int i = 0; i < NCH; i++)
            if (bus_addr == OFS_CMP0 + 8'(4 * i))
                bus_rdata = 32'(cmp[i]);
    end

    a_r8_once_self_clear: assert property (@(posedge clk) disable iff (rst)
        (once_done && !cfg_wr) |=> !cfg.once);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CMP_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] pwm_n
);

    localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

    cfg_t                      cfg;
    logic [NCH-1:0][CMP_W-1:0] cmp;
    logic [CNT_W-1:0]          cnt, cnt_val;
    logic [CMP_W-1:0]          scaled;
    logic [NCH-1:0]            flags;
    logic                      run, wrap, cnt_load;

    assign run = cfg.always_on || cfg.once;

    pwm_regs #(.NCH(NCH), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .scaled(scaled), .flags(flags), .once_done(wrap),
        .cfg(cfg), .cmp(cmp), .cnt_load(cnt_load), .cnt_val(cnt_val)
    );

    pwm_counter #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .scale(cfg.scale),
        .load(cnt_load), .load_val(cnt_val),
        .cnt(cnt), .scaled(scaled), .wrap(wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_chan #(.CMP_W(CMP_W)) u_ch (
            .clk(clk), .rst(rst), .run(run), .clr(wrap || cnt_load),
            .scaled(scaled), .cmp(cmp[i]),
            .out_n(pwm_n[i]), .flag(flags[i])
        );
    end

endmodule

// File: tb/pwm_timer_test.sv
module pwm_timer_test;

    localparam int NCH   = 4;
    localparam int CMP_W = 4;
    localparam int NV    = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_sel = 1'b0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_addr = 8'h00;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_n;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwm_timer #(.NCH(NCH), .CMP_W(CMP_W)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_n(pwm_n)
    );

    // scale, channel, compare, cycles run, expected scaled, pwm_n bit, flag
    localparam int VEC [NV][7] = '{
        '{0, 0,  5,  3,  3, 0, 0},
        '{0, 0,  5,  9,  9, 1, 1},
        '{0, 1, 15, 14, 14, 0, 0},
        '{0, 0, 15, 16,  0, 0, 0},
        '{1, 2,  3,  5,  2, 0, 0},
        '{1, 2,  3,  7,  3, 1, 1},
        '{2, 2,  8, 40, 10, 1, 1},
        '{2, 3,  0, 10,  2, 1, 1},
        '{0, 1,  1, 20,  4, 1, 1},
        '{3, 0,  2,  7,  0, 0, 0}
    };

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, v2, lows0, lows1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 cfg", v, 0);
        rd(8'h08, v); check("R1 count", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(8'h20 + 8'(4 * i), v); check("R1 cmp", v, 0);
        end
        check("R1 outputs", int'(pwm_n), 'hF);

        // R2 stored bits, flag bits ignored (R9), compare width, unmapped
        wr(8'h00, 32'hEFFF_CFFF);
        rd(8'h00, v); check("R2 cfg stored bits / R9 flag write ignored", v, 32'h0101_070F);
        wr(8'h28, 32'h1234_ABCD);
        rd(8'h28, v); check("R2 cmp2 width", v, 'hD);
        rd(8'h24, v); check("R2 cmp1 untouched", v, 0);
        rd(8'h04, v); check("R2 unmapped", v, 0);

        // R10 raw counter load, R4 scaled view
        wr(8'h00, 32'h0000_0002);
        wr(8'h08, 32'h0000_001B);
        rd(8'h08, v); check("R10 raw load", v, 'h1B);
        rd(8'h10, v); check("R4 scaled s2", v, 6);
        wr(8'h00, 32'h0000_0003);
        wr(8'h08, 32'h0000_07F5);
        rd(8'h10, v); check("R4 scaled s3", v, 'hE);

        // R7 stopped outputs stay high
        wr(8'h08, 0);
        wr(8'h20, 15);
        check("R7 stopped high", int'(pwm_n[0]), 1);

        // table-driven runs: R3 R4 R5 R9
        for (int n = 0; n < NV; n++) begin
            wr(8'h00, 0);
            wr(8'h08, 0);
            wr(8'h20 + 8'(4 * VEC[n][1]), 32'(VEC[n][2]));
            wr(8'h00, 32'h0000_1000 | 32'(VEC[n][0]));
            repeat (VEC[n][3]) @(negedge clk);
            rd(8'h10, v); check("R3/R4 scaled count", v, VEC[n][4]);
            check("R5 output level", int'(pwm_n[VEC[n][1]]), VEC[n][5]);
            rd(8'h00, v); check("R9 match flag", (v >> (28 + VEC[n][1])) & 1, VEC[n][6]);
        end

        // R6 full-period duty: cmp 15 low 15 of 16, cmp 0 never low
        wr(8'h00, 0);
        wr(8'h08, 0);
        wr(8'h20, 15);
        wr(8'h24, 0);
        wr(8'h00, 32'h0000_1000);
        lows0 = 0; lows1 = 0;
        for (int c = 0; c < 16; c++) begin
            #1;
            if (!pwm_n[0]) lows0++;
            if (!pwm_n[1]) lows1++;
            @(negedge clk);
        end
        check("R6 max compare lows", lows0, 15);
        check("R6 zero compare lows", lows1, 0);

        // R3 hold when stopped
        wr(8'h00, 0);
        rd(8'h08, v);
        repeat (10) @(negedge clk);
        rd(8'h08, v2); check("R3 hold", v2, v);
        check("R7 outputs high after stop", int'(pwm_n), 'hF);

        // R8 single-period mode
        wr(8'h08, 0);
        wr(8'h20, 8);
        wr(8'h00, 32'h0000_2000);
        repeat (8) @(negedge clk);
        rd(8'h08, v); check("R8 mid count", v, 8);
        rd(8'h00, v); check("R8 once still set", (v >> 13) & 1, 1);
        repeat (8) @(negedge clk);
        rd(8'h08, v); check("R8 wrapped count", v, 0);
        rd(8'h00, v); check("R8 once cleared", (v >> 13) & 1, 0);
        repeat (5) @(negedge clk);
        rd(8'h08, v); check("R8 stays stopped", v, 0);
        check("R8 outputs high", int'(pwm_n), 'hF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule